// File: doc/BRIEF.md
# Block Move Copy Engine

This engine performs a repeated byte copy from one memory region to another, the way a 16-bit processor core carries out its block-move instructions. A start pulse latches the following values:

- a source bank byte and a destination bank byte;
- two 16-bit index registers, one for the source and one for the destination;
- a 16-bit count;
- a direction flag;
- an index-width flag.

The engine then works through one iteration per byte on a 24-bit bus master port. Each iteration reads one byte at the source address and writes the same byte to the destination address. It then steps both indexes, spends two idle cycles, and decides whether to go round again.

The count is tested before it is decremented. A count of N therefore moves N+1 bytes and leaves the count at all ones. Each iteration that will be followed by another raises a one-cycle repeat pulse; this marks where a surrounding core would rewind its program counter by three. The final value of the destination bank is kept as the data bank output. Instruction fetch and the servicing of interrupts between bytes stay outside this block.

Top module: `blkmove_engine`

## Requirements
- R1: Each iteration issues a read at address {source bank, source index}. It then issues a write at {destination bank, destination index} carrying the byte returned by that read. Because this order holds per byte, overlapping regions copy with sequential per-byte semantics.
- R2: From the cycle after an accepted start, `dbank_out` holds the destination bank byte of that move.
- R3: With `descend`=0 both indexes increase by one after each byte's write is accepted. With `descend`=1 both decrease by one. In 16-bit mode they wrap modulo 2^16.
- R4: With `idx8`=1 only bits [7:0] of each index change, wrapping within 8 bits, and bits [15:8] keep their start value.
- R5: A start count of N moves exactly N+1 bytes, and `cnt_out` reads 0xFFFF when `done` pulses.
- R6: `rerun` pulses once in every iteration whose count before the decrement was nonzero, so a move of count N gives N pulses.
- R7: After a write is acknowledged by `wr_ack`, `req_valid` stays low for exactly two cycles. The next read request, if any, appears on the third cycle.
- R8: While `req_valid` is high and `req_ready` is low, the request (valid, direction, address, data) holds stable.
- R9: `busy` is high from the cycle after an accepted start until the move finishes. `done` pulses for one cycle as `busy` falls. A `start` that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a move; sampled only when idle |
| descend | input | 1 | 1 = indexes decrease, 0 = increase |
| idx8 | input | 1 | 1 = 8-bit index stepping |
| src_bank | input | 8 | Source bank byte |
| dst_bank | input | 8 | Destination bank byte |
| x_in | input | 16 | Initial source index |
| y_in | input | 16 | Initial destination index |
| cnt_in | input | 16 | Initial count (bytes minus one) |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle pulse at move end |
| rerun | output | 1 | Pulse: iteration will repeat |
| x_out | output | 16 | Current source index |
| y_out | output | 16 | Current destination index |
| cnt_out | output | 16 | Current count |
| dbank_out | output | 8 | Data bank value (destination bank) |
| req_valid | output | 1 | Bus request valid |
| req_write | output | 1 | 1 = write request, 0 = read |
| req_addr | output | 24 | Bus request address |
| req_wdata | output | 8 | Write data |
| req_ready | input | 1 | Bus accepts request |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | 8 | Read data |
| wr_ack | input | 1 | Write completed |

## Verification
The assertions watch properties that must hold on every cycle:

- a request stays stable while it stalls;
- the bus is silent for exactly two cycles after each write acknowledge;
- the count is all ones whenever `done` pulses, and `busy` drops with it;
- a write request addresses the current destination index.

Other behaviours only show up in the bench's scenarios, because they need a reference copy of memory and the start values:

- correct data in overlapping regions in both directions;
- the final index values, including 8-bit and 16-bit wraparound;
- the number of repeat pulses;
- that a start during a move is ignored.

// File: rtl/blkmove_engine.sv
module blkmove_engine #(
  parameter int IDX_W  = 16,
  parameter int BANK_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    descend,
  input  logic                    idx8,
  input  logic [BANK_W-1:0]       src_bank,
  input  logic [BANK_W-1:0]       dst_bank,
  input  logic [IDX_W-1:0]        x_in,
  input  logic [IDX_W-1:0]        y_in,
  input  logic [IDX_W-1:0]        cnt_in,
  output logic                    busy,
  output logic                    done,
  output logic                    rerun,
  output logic [IDX_W-1:0]        x_out,
  output logic [IDX_W-1:0]        y_out,
  output logic [IDX_W-1:0]        cnt_out,
  output logic [BANK_W-1:0]       dbank_out,
  output logic                    req_valid,
  output logic                    req_write,
  output logic [BANK_W+IDX_W-1:0] req_addr,
  output logic [DATA_W-1:0]       req_wdata,
  input  logic                    req_ready,
  input  logic                    rd_valid,
  input  logic [DATA_W-1:0]       rd_data,
  input  logic                    wr_ack
);
  typedef enum logic [2:0] {S_IDLE, S_RREQ, S_RWAIT, S_WREQ, S_WWAIT, S_GAP1, S_GAP2} st_t;

  st_t               st;
  logic [BANK_W-1:0] sbank_q;
  logic              dn_q, n8_q;
  logic [DATA_W-1:0] byte_q;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] v,
                                            input logic dn, input logic nrw);
    logic [IDX_W-1:0] full;
    full = dn ? v - IDX_W'(1) : v + IDX_W'(1);
    return nrw ? {v[IDX_W-1:8], full[7:0]} : full;
  endfunction

  assign busy      = (st != S_IDLE);
  assign req_valid = (st == S_RREQ) || (st == S_WREQ);
  assign req_write = (st == S_WREQ);
  assign req_addr  = (st == S_WREQ) ? {dbank_out, y_out} : {sbank_q, x_out};
  assign req_wdata = byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sbank_q   <= '0;
      dbank_out <= '0;
      dn_q      <= 1'b0;
      n8_q      <= 1'b0;
      byte_q    <= '0;
      x_out     <= '0;
      y_out     <= '0;
      cnt_out   <= '0;
      done      <= 1'b0;
      rerun     <= 1'b0;
    end else begin
      done  <= 1'b0;
      rerun <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          sbank_q   <= src_bank;
          dbank_out <= dst_bank;
          dn_q      <= descend;
          n8_q      <= idx8;
          x_out     <= x_in;
          y_out     <= y_in;
          cnt_out   <= cnt_in;
          st        <= S_RREQ;
        end
        S_RREQ:  if (req_ready) st <= S_RWAIT;
        S_RWAIT: if (rd_valid) begin
          byte_q <= rd_data;
          st     <= S_WREQ;
        end
        S_WREQ:  if (req_ready) st <= S_WWAIT;
        S_WWAIT: if (wr_ack) begin
          x_out <= step(x_out, dn_q, n8_q);
          y_out <= step(y_out, dn_q, n8_q);
          st    <= S_GAP1;
        end
        S_GAP1: st <= S_GAP2;
        S_GAP2: begin
          cnt_out <= cnt_out - IDX_W'(1);
          if (cnt_out != '0) begin
            rerun <= 1'b1;
            st    <= S_RREQ;
          end else begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module blkmove_engine_chk #(
  parameter int IDX_W  = 16,
  parameter int BANK_W = 8,
  parameter int DATA_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    busy,
  input logic                    done,
  input logic [IDX_W-1:0]        y_out,
  input logic [IDX_W-1:0]        cnt_out,
  input logic                    req_valid,
  input logic                    req_write,
  input logic [BANK_W+IDX_W-1:0] req_addr,
  input logic [DATA_W-1:0]       req_wdata,
  input logic                    req_ready,
  input logic                    wr_ack
);
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_write) &&
                                   $stable(req_addr) && $stable(req_wdata)));

  a_r7_two_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && busy) |=> !req_valid ##1 !req_valid);

  a_r5_cnt_wrapped: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cnt_out == '1);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r1_wr_index: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> req_addr[IDX_W-1:0] == y_out);
endmodule

bind blkmove_engine blkmove_engine_chk #(.IDX_W(IDX_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .y_out(y_out), .cnt_out(cnt_out),
  .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
  .req_wdata(req_wdata), .req_ready(req_ready), .wr_ack(wr_ack));

// File: tb/blkmove_engine_bench.sv
module blkmove_engine_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, descend = 0, idx8 = 0;
  logic [7:0] src_bank = 0, dst_bank = 0;
  logic [15:0] x_in = 0, y_in = 0, cnt_in = 0;
  logic busy, done, rerun, req_valid, req_write;
  logic [15:0] x_out, y_out, cnt_out;
  logic [7:0] dbank_out, req_wdata;
  logic [23:0] req_addr;
  logic req_ready = 0, rd_valid = 0, wr_ack = 0;
  logic [7:0] rd_data = 0;

  int checks = 0, fails = 0, cyc = 0;
  int done_cnt = 0, rerun_cnt = 0;
  logic [7:0] mem [4096];
  logic [7:0] refm [4096];

  always #5 clk = ~clk;

  blkmove_engine u_blkmove_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .descend(descend), .idx8(idx8),
    .src_bank(src_bank), .dst_bank(dst_bank), .x_in(x_in), .y_in(y_in), .cnt_in(cnt_in),
    .busy(busy), .done(done), .rerun(rerun), .x_out(x_out), .y_out(y_out),
    .cnt_out(cnt_out), .dbank_out(dbank_out), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data), .wr_ack(wr_ack));

  function automatic int mi(input logic [23:0] a);
    return int'({a[17:16], a[9:0]});
  endfunction

  function automatic logic [15:0] nxt(input logic [15:0] v, input logic dn, input logic n8);
    logic [15:0] f;
    f = dn ? v - 16'd1 : v + 16'd1;
    return n8 ? {v[15:8], f[7:0]} : f;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bus responder and monitor
  logic pf = 0, pw = 0, hold_v = 0, gap_arm = 0;
  logic [23:0] pa = 0, hold_a = 0;
  logic [7:0] pd = 0, rdat = 0;
  int rdly = -1, wdly = -1, wa = 0;
  initial forever begin
    @(negedge clk);
    cyc++;
    rd_valid = 0;
    wr_ack = 0;
    if (pf) begin
      if (pw) begin mem[mi(pa)] = pd; wdly = int'($urandom % 3); end
      else begin rdat = mem[mi(pa)]; rdly = int'($urandom % 3); end
    end
    if (rdly == 0) begin rd_valid = 1; rd_data = rdat; rdly = -1; end
    else if (rdly > 0) rdly--;
    if (wdly == 0) begin wr_ack = 1; wdly = -1; wa = cyc; gap_arm = 1; end
    else if (wdly > 0) wdly--;
    if (hold_v) chk("R8 hold", {7'd0, req_valid, req_addr}, {8'd1, hold_a});
    if (req_valid && !req_write && gap_arm) begin
      chk("R7 gap", cyc - wa, 3);
      gap_arm = 0;
    end
    if (done) begin done_cnt++; gap_arm = 0; end
    if (rerun) rerun_cnt++;
    req_ready = rst_n && req_valid && ($urandom % 3 != 0);
    pf = req_valid && req_ready;
    pw = req_write; pa = req_addr; pd = req_wdata;
    hold_v = req_valid && !req_ready;
    hold_a = req_addr;
  end

  task automatic run_move(input logic [7:0] sb, input logic [7:0] db, input logic [15:0] x,
                          input logic [15:0] y, input logic [15:0] c, input logic dn,
                          input logic n8, input bit poke);
    logic [15:0] ex, ey, cc;
    int d0, r0, bad;
    ex = x; ey = y; cc = c;
    for (int k = 0; k < 70000; k++) begin
      refm[mi({db, ey})] = refm[mi({sb, ex})];
      ex = nxt(ex, dn, n8);
      ey = nxt(ey, dn, n8);
      if (cc == 0) break;
      cc--;
    end
    d0 = done_cnt; r0 = rerun_cnt;
    src_bank = sb; dst_bank = db; x_in = x; y_in = y; cnt_in = c;
    descend = dn; idx8 = n8; start = 1;
    @(negedge clk);
    start = 0;
    chk("R9 busy after start", busy, 1);
    chk("R2 data bank", dbank_out, db);
    if (poke) begin
      src_bank = sb ^ 8'h01; x_in = x ^ 16'h0011; cnt_in = c + 16'd5; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (done_cnt == d0) @(negedge clk);
    chk("R9 busy low at done", busy, 0);
    chk(n8 ? "R4 src index" : "R3 src index", x_out, ex);
    chk(n8 ? "R4 dst index" : "R3 dst index", y_out, ey);
    chk("R5 count end", cnt_out, 16'hffff);
    chk("R6 repeat pulses", rerun_cnt - r0, c);
    bad = 0;
    for (int i = 0; i < 4096; i++) if (mem[i] !== refm[i]) bad++;
    chk(poke ? "R9 start ignored, memory" : "R1 memory copy", bad, 0);
    for (int i = 0; i < 4096; i++) refm[i] = mem[i];
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4096; i++) begin mem[i] = 8'($urandom); refm[i] = mem[i]; end
    repeat (3) @(negedge clk);
    chk("R9 reset busy", busy, 0);
    chk("R9 reset done", done, 0);
    chk("R8 reset valid", req_valid, 0);
    rst_n = 1;
    @(negedge clk);
    run_move(8'h00, 8'h01, 16'h0010, 16'h0020, 16'd0, 0, 0, 0);      // R5 single byte
    run_move(8'h02, 8'h02, 16'h0100, 16'h0101, 16'd7, 0, 0, 0);      // R1 overlap up
    run_move(8'h03, 8'h03, 16'h0200, 16'h01FF, 16'd9, 1, 0, 0);      // R1 overlap down
    run_move(8'h00, 8'h02, 16'h12FE, 16'h34FD, 16'd4, 0, 1, 0);      // R4 8-bit wrap up
    run_move(8'h01, 8'h00, 16'h5601, 16'h7802, 16'd3, 1, 1, 0);      // R4 8-bit wrap down
    run_move(8'h02, 8'h01, 16'h0001, 16'h0002, 16'd3, 1, 0, 0);      // R3 16-bit wrap
    run_move(8'h00, 8'h03, 16'hFFFE, 16'h0300, 16'd3, 0, 0, 0);      // R3 16-bit wrap up
    run_move(8'h01, 8'h02, 16'h0040, 16'h0080, 16'd5, 0, 0, 1);      // R9 start while busy
    for (int n = 0; n < 20; n++)
      run_move(8'($urandom % 4), 8'($urandom % 4), 16'($urandom), 16'($urandom),
               16'($urandom % 24), 1'($urandom), 1'($urandom), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule